// File: doc/BRIEF.md
# Decimation Chain Slot Scheduler

This block sequences one shared filter engine across a dual (in-phase and quadrature) cascade of half-band filters, each followed by a 2:1 decimator. Each stage in the cascade runs at half the rate of the stage before it. A binary slot counter, decoded by its lowest set bit, therefore gives every stage a share of slots that matches its rate. Stage 0 gets every fourth slot per component, stage 1 every eighth, and so on. The count in which all stage bits are zero is left spare.

Each sample-valid pulse from the upstream rotator opens a group of time slots of fixed length. At the start of every slot the scheduler decodes the current counter value into a RAM page address: the stage index joined to the I/Q select bit. It then advances the counter. For a slot that names a filter, it issues a one-cycle start pulse to the engine. When the engine reports done for one of the tapped pages, the scheduler raises a matching ready strobe for downstream consumers. The engine and the state RAM sit outside this block.

Top module: `decim_slot_sched`

## Requirements
- R1: During and right after reset, the slot counter is zero, the block is idle, and `start_o`, `slot_vld_o`, `page_o` and `tap_rdy_o` are all zero.
- R2: When a clock edge samples `smp_vld_i` high, a group of SLOTS_PER_SAMPLE slots begins, each SLOT_CYCLES clocks long. The first slot's outputs are visible right after that edge. Once the group's last slot ends, the block stays idle, with `slot_vld_o` low and no start pulse, until the next `smp_vld_i`.
- R3: The slot counter (NUM_STAGES+1 bits) advances by exactly one per slot and does not move while idle. Its LSB forms the I/Q select, which is `page_o` bit 0 (0 = I, 1 = Q).
- R4: For a valid slot, `page_o[PAGE_W-1:1]` carries the index of the lowest set bit among counter bits [NUM_STAGES:1].
- R5: When counter bits [NUM_STAGES:1] are all zero, the slot is unused: `slot_vld_o` stays low, no start pulse is issued, and `page_o` reads zero.
- R6: A valid slot raises `start_o` for exactly its first cycle and holds `slot_vld_o` high and `page_o` stable for its whole length.
- R7: Over 2^(NUM_STAGES+1) consecutive slots, stage k is scheduled 2^(NUM_STAGES-1-k) times as I and the same number of times as Q. Exactly two slots are unused, and the pattern then repeats after the counter wraps.
- R8: When `done_i` is high in a cycle of a valid slot whose page is tapped, the matching `tap_rdy_o` bit is high for the next cycle only. Bit order: bit0 = stage 2 I, bit1 = stage 3 Q, bit2 = stage 8 I, bit3 = stage 8 Q, bit4 = stage 13 I, bit5 = stage 13 Q.
- R9: `done_i` has no effect while idle, during unused slots, or during slots whose page is not tapped.
- R10: A `smp_vld_i` pulse during a running group abandons that group and starts a fresh group of SLOTS_PER_SAMPLE slots, using the next counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample-valid pulse from the rotator; opens a slot group |
| done_i | input | 1 | Engine has finished the filter on the current page |
| start_o | output | 1 | One-cycle pulse: begin computing the filter on `page_o` |
| page_o | output | PAGE_W (5) | RAM page: {stage index, I/Q select} |
| slot_vld_o | output | 1 | The current slot names a filter |
| tap_rdy_o | output | 6 | Ready strobes for the tapped stage outputs (order in R8) |

## Verification
The bench builds the block with NUM_STAGES = 14 and SLOTS_PER_SAMPLE = 4, as in the intended use, but shortens SLOT_CYCLES to 3. With 13-cycle groups, one full counter period of 32768 slots fits in the run. Every slot is checked against a model of the lowest-set-bit decode, and a per-stage histogram then confirms the binary rate split and the counter wrap. Engine completion is driven in every slot, including unused ones, so all six tap strobes fire and every non-tapped page shows none. Separate scenarios cover idle gaps and a mid-group resynchronisation.

// File: rtl/sched_pkg.sv
package sched_pkg;
    // Tapped filter outputs: stage index and I/Q select, in strobe bit order.
    localparam int NUM_TAPS = 6;
    localparam int TAP_STAGE [NUM_TAPS] = '{2, 3, 8, 8, 13, 13};
    localparam int TAP_IQ    [NUM_TAPS] = '{0, 1, 0, 1, 0, 1};
endpackage

// File: rtl/sched_lowest_one.sv
// Finds the lowest set bit of a vector and reports its index.
module sched_lowest_one #(
    parameter int W  = 14,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |vec_i;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/sched_tap_match.sv
// Compares the current page against each tapped page and qualifies with done.
module sched_tap_match
    import sched_pkg::*;
#(
    parameter int PAGE_W = 5
) (
    input  logic [PAGE_W-1:0]   page_i,
    input  logic                vld_i,
    input  logic                done_i,
    output logic [NUM_TAPS-1:0] hit_o
);
    for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
        localparam logic [PAGE_W-1:0] TP = PAGE_W'(TAP_STAGE[j] * 2 + TAP_IQ[j]);
        assign hit_o[j] = vld_i && done_i && (page_i == TP);
    end
endmodule

// File: rtl/decim_slot_sched.sv
module decim_slot_sched #(
    parameter int NUM_STAGES       = 14,
    parameter int SLOT_CYCLES      = 18,
    parameter int SLOTS_PER_SAMPLE = 4,
    localparam int STG_W    = $clog2(NUM_STAGES),
    localparam int PAGE_W   = STG_W + 1,
    localparam int NUM_TAPS = sched_pkg::NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld_i,
    input  logic                done_i,
    output logic                start_o,
    output logic [PAGE_W-1:0]   page_o,
    output logic                slot_vld_o,
    output logic [NUM_TAPS-1:0] tap_rdy_o
);
    localparam int CTR_W = NUM_STAGES + 1;
    localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int SLT_W = (SLOTS_PER_SAMPLE > 1) ? $clog2(SLOTS_PER_SAMPLE) : 1;

    typedef struct packed {
        logic                active;
        logic [CYC_W-1:0]    cyc;
        logic [SLT_W-1:0]    slot;
        logic [CTR_W-1:0]    ctr;
        logic [PAGE_W-1:0]   page;
        logic                slot_vld;
        logic                start;
        logic [NUM_TAPS-1:0] tap;
    } state_t;

    state_t st_d, st_q;
    logic [STG_W-1:0] stage_idx;
    logic             stage_any;
    logic [NUM_TAPS-1:0] tap_hit;
    logic             slot_begin;

    // Stage select: lowest set bit of the counter above the I/Q bit.
    sched_lowest_one #(.W(NUM_STAGES)) u_lsb (
        .vec_i (st_q.ctr[CTR_W-1:1]),
        .idx_o (stage_idx),
        .any_o (stage_any)
    );

    sched_tap_match #(.PAGE_W(PAGE_W)) u_tap (
        .page_i (st_q.page),
        .vld_i  (st_q.slot_vld),
        .done_i (done_i),
        .hit_o  (tap_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.tap   = tap_hit;
        slot_begin = 1'b0;
        if (smp_vld_i) begin
            slot_begin = 1'b1;
            st_d.slot  = '0;
        end else if (st_q.active && st_q.cyc == CYC_W'(SLOT_CYCLES - 1)) begin
            if (st_q.slot == SLT_W'(SLOTS_PER_SAMPLE - 1)) begin
                st_d.active   = 1'b0;
                st_d.slot_vld = 1'b0;
                st_d.page     = '0;
            end else begin
                slot_begin = 1'b1;
                st_d.slot  = st_q.slot + 1'b1;
            end
        end else if (st_q.active) begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
        if (slot_begin) begin
            st_d.active   = 1'b1;
            st_d.cyc      = '0;
            st_d.ctr      = st_q.ctr + 1'b1;
            st_d.page     = stage_any ? {stage_idx, st_q.ctr[0]} : '0;
            st_d.slot_vld = stage_any;
            st_d.start    = stage_any;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o    = st_q.start;
    assign page_o     = st_q.page;
    assign slot_vld_o = st_q.slot_vld;
    assign tap_rdy_o  = st_q.tap;
endmodule

// File: rtl/decim_slot_sched_chk.sv
module decim_slot_sched_chk #(
    parameter int NUM_STAGES = 14,
    parameter int PAGE_W     = 5,
    parameter int NUM_TAPS   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_vld_i,
    input logic                done_i,
    input logic                start_o,
    input logic [PAGE_W-1:0]   page_o,
    input logic                slot_vld_o,
    input logic [NUM_TAPS-1:0] tap_rdy_o
);
    // R6: start lasts one cycle unless a resync begins a new slot
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && !smp_vld_i |=> !start_o);

    // R6: a start pulse only accompanies a valid slot
    a_r6_start_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> slot_vld_o);

    // R6: page held inside a valid slot
    a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_o && $past(slot_vld_o) && !start_o |-> $stable(page_o));

    // R4: stage field names an existing stage
    a_r4_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_o |-> (int'(page_o[PAGE_W-1:1]) < NUM_STAGES));

    // R5: no page is presented outside a valid slot
    a_r5_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld_o |-> page_o == '0);

    // R8: a strobe is caused by done in a valid slot
    a_r8_tap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|tap_rdy_o) |-> $past(done_i && slot_vld_o));

    // R8: at most one strobe at a time
    a_r8_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_rdy_o));
endmodule

bind decim_slot_sched decim_slot_sched_chk #(
    .NUM_STAGES (NUM_STAGES),
    .PAGE_W     (PAGE_W),
    .NUM_TAPS   (NUM_TAPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld_i  (smp_vld_i),
    .done_i     (done_i),
    .start_o    (start_o),
    .page_o     (page_o),
    .slot_vld_o (slot_vld_o),
    .tap_rdy_o  (tap_rdy_o)
);

// File: tb/sim_decim_slot_sched.sv
module sim_decim_slot_sched;
    localparam int NS  = 14;
    localparam int SC  = 3;
    localparam int SPG = 4;
    localparam int PW  = 5;
    localparam int NT  = 6;
    localparam int PERIOD = 32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic done = 1'b0;
    logic start;
    logic [PW-1:0] page;
    logic svld;
    logic [NT-1:0] tap;

    int n_chk = 0;
    int n_bad = 0;
    int e_ctr = 0;
    int hist [NS][2];
    int unused_cnt = 0;
    int tap_pg [NT] = '{4, 7, 16, 17, 26, 27};

    always #2 clk = ~clk;

    decim_slot_sched #(
        .NUM_STAGES(NS), .SLOT_CYCLES(SC), .SLOTS_PER_SAMPLE(SPG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .done_i(done),
        .start_o(start), .page_o(page), .slot_vld_o(svld), .tap_rdy_o(tap)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic bit ex_vld(int c);
        return ((c >> 1) & 32'h3fff) != 0;
    endfunction

    function automatic int ex_stage(int c);
        int u = (c >> 1) & 32'h3fff;
        for (int k = 0; k < NS; k++) if (u[k]) return k;
        return 0;
    endfunction

    function automatic int ex_page(int c);
        return ex_vld(c) ? ex_stage(c) * 2 + (c & 1) : 0;
    endfunction

    function automatic int ex_tap(int c);
        int r = 0;
        if (ex_vld(c))
            for (int j = 0; j < NT; j++) if (ex_page(c) == tap_pg[j]) r |= (1 << j);
        return r;
    endfunction

    // Called at the negedge after a slot begins; returns at the next slot's negedge.
    task automatic run_slot(bit dd);
        int c = e_ctr;
        chk("R3/R4 page", page, ex_page(c));
        chk("R5/R6 slot valid", svld, ex_vld(c));
        chk("R6 start", start, ex_vld(c));
        if (ex_vld(c)) hist[ex_stage(c)][c & 1]++;
        else unused_cnt++;
        done = dd;
        @(negedge clk);
        chk("R8/R9 tap strobe", tap, dd ? ex_tap(c) : 0);
        chk("R6 start width", start, 0);
        chk("R6 page hold", page, ex_page(c));
        done = 1'b0;
        e_ctr = (e_ctr + 1) % PERIOD;
        repeat (SC - 1) @(negedge clk);
    endtask

    task automatic check_gap(string rq);
        chk({rq, " idle valid"}, svld, 0);
        chk({rq, " idle start"}, start, 0);
        chk({rq, " idle tap"}, tap, 0);
    endtask

    // Caller is at a negedge.
    task automatic run_group(bit dd);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        for (int s = 0; s < SPG; s++) run_slot(dd);
        check_gap("R2 group end");
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check_gap("R1 in reset");
        chk("R1 page", page, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_gap("R1 after reset");
        chk("R1 page after reset", page, 0);
    endtask

    task automatic t_first_group;
        // counter 0,1 unused; 2 -> stage0 I (page 0); 3 -> stage0 Q (page 1)
        run_group(1'b1);
        chk("R5 unused slots at start", unused_cnt, 2);
        chk("R4 stage0 I and Q seen", hist[0][0] + hist[0][1], 2);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 20; i++) begin
            done = i[0];
            @(negedge clk);
            check_gap("R2 R9 idle");
        end
        done = 1'b0;
        run_group(1'b0);
    endtask

    task automatic t_resync;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        run_slot(1'b1);
        chk("R10 page before resync", page, ex_page(e_ctr));
        e_ctr = (e_ctr + 1) % PERIOD;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        for (int s = 0; s < SPG; s++) run_slot(1'b1);
        check_gap("R10 fresh group length");
    endtask

    task automatic t_period;
        foreach (hist[k, q]) hist[k][q] = 0;
        unused_cnt = 0;
        for (int g = 0; g < PERIOD / SPG; g++) run_group(1'b1);
        for (int k = 0; k < NS; k++) begin
            chk($sformatf("R7 stage %0d I count", k), hist[k][0], 1 << (NS - 1 - k));
            chk($sformatf("R7 stage %0d Q count", k), hist[k][1], 1 << (NS - 1 - k));
        end
        chk("R7 unused count", unused_cnt, 2);
        run_group(1'b1);   // after wrap: same opening pattern
    endtask

    initial begin
        foreach (hist[k, q]) hist[k][q] = 0;
        t_reset();
        t_first_group();
        t_idle();
        t_resync();
        t_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule